// File: doc/BRIEF.md
# Event-Triggered Biosignal History Buffer

This block keeps a rolling window of the most recent one-byte ECG samples in a circular on-chip array. With samples arriving at 256 per second and a default depth of 2048 bytes, the window covers the last 8 seconds of signal. Up to that point the array is still filling. Once it is full, each new sample overwrites the oldest one.

When an arrhythmia detector raises its event flag, capture stops and the stored history is frozen. The block then streams the history to the transmit path, oldest sample first, over a valid/ready byte interface. The final byte is marked with a last flag. Only the samples actually held are sent.

While the dump is running, incoming samples are dropped. Further events are refused and reported on an error pulse. When the dump ends, the block returns to capture with an empty window.

Top module: `evt_history_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_last`, `busy` and `evt_err` are all low.
- R2: In capture mode, every cycle with `smp_en` high and `evt` low stores `smp_data`. The window keeps the most recent DEPTH samples (default 2048, which is 8 s at 256 samples/s).
- R3: An event in capture mode with at least one stored sample makes `busy` and `out_valid` high in the following cycle. A sample offered in the same cycle as the event is not stored.
- R4: Bytes leave oldest first. If more than DEPTH samples were written, the first byte is the sample written DEPTH writes before the event; otherwise it is the first sample written since capture began.
- R5: The dump carries exactly min(samples written, DEPTH) bytes, and `out_last` is high only together with the final byte.
- R6: A byte is consumed only in a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R7: Samples offered during the dump are discarded. In the cycle after the final byte is accepted, `busy` and `out_valid` are low, and capture restarts with an empty window.
- R8: An event during the dump leaves the byte stream unchanged and raises `evt_err` for exactly the following cycle.
- R9: An event while the window is empty is ignored: `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | A new sample is present this cycle |
| smp_data | input | DATA_W | Sample byte |
| evt | input | 1 | Arrhythmia event from the detector |
| out_ready | input | 1 | Downstream accepts a byte |
| out_valid | output | 1 | A history byte is offered |
| out_data | output | DATA_W | History byte |
| out_last | output | 1 | Marks the final byte of the dump |
| busy | output | 1 | Dump in progress |
| evt_err | output | 1 | One-cycle flag for an event refused during the dump |

## Verification
The assertions assume that `out_ready` is a free input. They also assume that `evt` may arrive in any cycle, including the cycle in which the last byte is accepted, and that nothing else writes the array while a dump is running.

The bench sweeps the number of samples written before an event from zero to well past two window depths. Because every dump returns the block to an empty state, each run in the sweep is independent. Stray samples during the dump, an event in the same cycle as a sample, a second event mid-dump, and alternating `out_ready` are all applied inside those legal bounds.

// File: rtl/evh_pkg.sv
package evh_pkg;
  typedef enum logic {
    EVH_CAPTURE = 1'b0,
    EVH_DUMP    = 1'b1
  } evh_state_e;
endpackage

// File: rtl/evh_mem.sv
module evh_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2048,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/evh_wr_ctrl.sv
module evh_wr_ctrl #(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          clr,
  output logic [AW-1:0] wr_ptr,
  output logic [AW:0]   fill,
  output logic          full
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP       = (AW+1)'(DEPTH);

  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW:0]   fill_q, fill_d;

  always_comb begin
    ptr_d  = ptr_q;
    fill_d = fill_q;
    if (clr) begin
      ptr_d  = '0;
      fill_d = '0;
    end else if (wr_en) begin
      ptr_d = (ptr_q == LAST_ADDR) ? '0 : ptr_q + 1'b1;
      if (fill_q != CAP) begin
        fill_d = fill_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      fill_q <= fill_d;
    end
  end

  assign wr_ptr = ptr_q;
  assign fill   = fill_q;
  assign full   = (fill_q == CAP);
endmodule

// File: rtl/evh_rd_ctrl.sv
module evh_rd_ctrl
  import evh_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW:0]   fill,
  input  logic          full,
  input  logic          out_ready,
  output logic [AW-1:0] rd_ptr,
  output logic          dumping,
  output logic          out_last,
  output logic          dump_done,
  output logic          evt_err
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  evh_state_e    state_q, state_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [AW:0]   left_q, left_d;
  logic          err_q, err_d;

  always_comb begin
    state_d   = state_q;
    rd_d      = rd_q;
    left_d    = left_q;
    err_d     = 1'b0;
    dump_done = 1'b0;
    case (state_q)
      EVH_CAPTURE: begin
        if (evt && (fill != '0)) begin
          state_d = EVH_DUMP;
          rd_d    = full ? wr_ptr : '0;
          left_d  = fill;
        end
      end
      EVH_DUMP: begin
        err_d = evt;
        if (out_ready) begin
          rd_d   = (rd_q == LAST_ADDR) ? '0 : rd_q + 1'b1;
          left_d = left_q - 1'b1;
          if (left_q == (AW+1)'(1)) begin
            state_d   = EVH_CAPTURE;
            dump_done = 1'b1;
          end
        end
      end
      default: state_d = EVH_CAPTURE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EVH_CAPTURE;
      rd_q    <= '0;
      left_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      left_q  <= left_d;
      err_q   <= err_d;
    end
  end

  assign rd_ptr   = rd_q;
  assign dumping  = (state_q == EVH_DUMP);
  assign out_last = dumping && (left_q == (AW+1)'(1));
  assign evt_err  = err_q;
endmodule

// File: rtl/evt_history_buf.sv
module evt_history_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              evt,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              busy,
  output logic              evt_err
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;
  logic          full, dumping, dump_done, wr_en;

  assign wr_en = smp_en && !dumping && !evt;

  evh_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .clr    (dump_done),
    .wr_ptr (wr_ptr),
    .fill   (fill),
    .full   (full)
  );

  evh_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (smp_data),
    .raddr (rd_ptr),
    .rdata (out_data)
  );

  evh_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .wr_ptr    (wr_ptr),
    .fill      (fill),
    .full      (full),
    .out_ready (out_ready),
    .rd_ptr    (rd_ptr),
    .dumping   (dumping),
    .out_last  (out_last),
    .dump_done (dump_done),
    .evt_err   (evt_err)
  );

  assign out_valid = dumping;
  assign busy      = dumping;
endmodule

// File: rtl/evh_checker.sv
module evh_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              busy,
  input logic              evt_err
);
  p_last_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(evt));

  p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!busy && !out_valid));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> ($past(busy) && $past(evt)));
endmodule

bind evt_history_buf evh_checker #(.DATA_W(DATA_W)) u_evh_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt       (evt),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .busy      (busy),
  .evt_err   (evt_err)
);

// File: tb/evt_history_buf_bench.sv
module evt_history_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int DEPTH      = 8;
  localparam int MAX_N      = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_en, evt, out_ready;
  logic [DW-1:0] smp_data;
  logic          out_valid, out_last, busy, evt_err;
  logic [DW-1:0] out_data;

  int vectors   = 0;
  int miscomp   = 0;
  bit finished  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_history_buf #(.DATA_W(DW), .DEPTH(DEPTH)) u_evt_history_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .smp_data  (smp_data),
    .evt       (evt),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .busy      (busy),
    .evt_err   (evt_err)
  );

  function automatic logic [DW-1:0] pat(int n, int i);
    return DW'((n * 37 + i * 5 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_case(int n);
    int m;
    int k;
    int cyc;
    bit r;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_en = 1'b1; smp_data = pat(n, i); evt = 1'b0;
    end
    @(negedge clk);
    smp_en = (n == 5); smp_data = 8'hEE; evt = 1'b1;   // R3 same-cycle sample dropped
    @(negedge clk);
    evt = 1'b0; smp_en = 1'b1; smp_data = 8'hA5;       // R7 junk during dump
    m = (n < DEPTH) ? n : DEPTH;
    if (m == 0) begin
      chk(busy == 1'b0, "R9 busy", busy, 0);
      chk(out_valid == 1'b0, "R9 valid", out_valid, 0);
      smp_en = 1'b0;
      return;
    end
    chk(busy == 1'b1, "R3 busy", busy, 1);
    k = 0;
    cyc = 0;
    while (k < m && cyc < 200) begin
      chk(out_valid == 1'b1, "R3 valid", out_valid, 1);
      chk(out_data == pat(n, n - m + k), "R4 data", out_data, pat(n, n - m + k));
      chk(out_last == (k == m - 1), "R5 last", out_last, (k == m - 1));
      if (n == 12) chk(evt_err == (cyc == 2), "R8 err", evt_err, (cyc == 2));
      r = (n % 2 == 1) ? cyc[0] : 1'b1;                // R6 backpressure on odd n
      out_ready = r;
      evt = (n == 12 && cyc == 1);
      @(negedge clk);
      if (r) k++;
      cyc++;
    end
    evt = 1'b0; out_ready = 1'b0; smp_en = 1'b0;
    chk(k == m, "R5 count", k, m);
    chk(busy == 1'b0, "R7 busy", busy, 0);
    chk(out_valid == 1'b0, "R7 valid", out_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; smp_en = 1'b0; evt = 1'b0; out_ready = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(out_last == 1'b0, "R1 last", out_last, 0);
    chk(evt_err == 1'b0, "R1 err", evt_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R1 post", busy, 0);
    // R2 sweep: fill counts from empty through more than two windows
    for (int n = 0; n <= MAX_N; n++) begin
      run_case(n);
    end
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule